// File: doc/BRIEF.md
# Supervisor Fault-Cause Register with Two-Wire Read and Write

This block records which monitored event last pulled a supervised system into reset. There are five events: a manual-reset request, a watchdog expiry and three supply-undervoltage comparators. Each event arrives as a synchronous one-cycle strobe or as a level. The register holds one active-low sticky flag per event. It comes out of reset as all zeros and reports nothing until the host arms it by writing all ones. After that, each failure clears its own flag, and the flag stays cleared until the host writes it back to 1.

The host reaches the register through a two-wire serial slave. SCL and SDA are synchronized to the system clock. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The slave decodes a 7-bit device address, one register address (0xFF by default) and one data byte. A write replaces the register contents. A read is a random read: the master sets the pointer with a write frame, issues a repeated start, then reads one byte and answers it with a NACK.

The slave FSM has these states:
- S_IDLE: waits for a start condition.
- S_DEVADDR: shifts in the device address byte.
- S_DEVACK: drives the device-address ACK.
- S_REGADDR: shifts in the register address.
- S_REGACK: drives the register-address ACK.
- S_WRDATA: shifts in the data byte.
- S_WRACK: drives the data ACK.
- S_RDDATA: shifts the register byte out, MSB first.
- S_RDACK: leaves SDA released for the master's acknowledge bit.
- S_IGNORE: waits for the next start or stop.

Transitions:
- A start leads from any state to S_DEVADDR.
- A stop leads from any state to S_IDLE.
- After eight bits, each receive state moves to its ACK state or to S_IGNORE.
- Each ACK state moves on at the falling SCL edge that ends the ACK bit.
- S_RDACK moves to S_IGNORE at the master's acknowledge clock.

Top module: `fault_cause_reg`

## Requirements
- R1: After reset the register reads 0x00 and the slave does not pull SDA low.
- R2: A flag is sticky. An event clears its bit at the next clock edge. No bit ever goes from 0 to 1 except through a host write, and a host write of 0xFF re-arms all flags.
- R3: Bit map: bit 7 is manual reset, bit 6 is watchdog, bit 0 is low supply 1, bit 1 is low supply 2 and bit 2 is low supply 3. Bits 5 to 3 are plain storage that only a host write changes.
- R4: The write sequence is start, then device address 0x50 with R/W=0, then register address 0xFF, then one data byte, then stop. The slave ACKs each of the three bytes, and the register then holds the data byte.
- R5: If an event is active in the cycle a host write commits, that event's bit ends up 0 whatever the written value.
- R6: The read sequence is a write frame that sets the pointer, a repeated start, device address with R/W=1, and one byte. The slave returns that byte MSB first and releases SDA during the master's acknowledge bit.
- R7: A register address other than 0xFF is NACKed. The data byte that follows is neither acknowledged nor written.
- R8: A device address other than 0x50 gets no ACK, and the slave keeps SDA released for the rest of the frame.
- R9: Before a start condition, bus activity is ignored: no ACK, no write, and the slave stays idle.
- R10: A stop returns the slave to idle with SDA released. A repeated start restarts address decoding.
- R11: A read request is ACKed only if the register address 0xFF was received earlier in the same transaction. A stop clears that pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_manual | input | 1 | Manual-reset event, active high |
| fail_wdog | input | 1 | Watchdog expiry event, active high |
| fail_low1 | input | 1 | Supply 1 under trip level, active high |
| fail_low2 | input | 1 | Supply 2 under trip level, active high |
| fail_low3 | input | 1 | Supply 3 under trip level, active high |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| flags | output | 8 | Current fault-cause register |

## Verification
The checker watches the flag store on every cycle. It checks that no bit ever rises without a committed write, that an active event always clears its bit on the next edge even against a write, and that a write leaves exactly the masked data byte. It also checks that a stop always returns the FSM to idle, and that without a start the idle FSM stays idle and releases SDA.

Only the bench scenarios can show the serial side end to end: which bytes get ACKed or NACKed, the bit order of the read byte, and the pointer rule that ties a read to the same transaction. The bench's cycle model of the flags follows the event pins between transfers.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_DEVACK,
        S_REGADDR,
        S_REGACK,
        S_WRDATA,
        S_WRACK,
        S_RDDATA,
        S_RDACK,
        S_IGNORE
    } fcr_state_e;

    localparam int FLAG_W   = 8;
    localparam int BIT_MAN  = 7;
    localparam int BIT_WDG  = 6;
    localparam int BIT_LOW3 = 2;
    localparam int BIT_LOW2 = 1;
    localparam int BIT_LOW1 = 0;

endpackage

// File: rtl/fcr_bus_sync.sv
module fcr_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= {STAGES{1'b1}};
            sda_sh <= {STAGES{1'b1}};
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign sda_lvl   = sda_s;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/fcr_flag_store.sv
module fcr_flag_store
    import fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] fail_vec,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (wr_en) begin
            flags <= wr_data & ~fail_vec;
        end else begin
            flags <= flags & ~fail_vec;
        end
    end
endmodule

// File: rtl/fcr_slave_fsm.sv
module fcr_slave_fsm
    import fcr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter logic [7:0] REG_ADDR = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sda_lvl,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic [7:0]  rd_byte,
    output logic        sda_pull,
    output logic        wr_en,
    output logic [7:0]  wr_data,
    output fcr_state_e  state
);
    localparam logic [3:0] BITS = 4'd8;

    fcr_state_e state_q, state_d;
    logic [7:0] sh_q, sh_d;
    logic [3:0] cnt_q, cnt_d;
    logic       ptr_q, ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            ptr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cnt_d   = cnt_q;
        ptr_d   = ptr_q;
        wr_en   = 1'b0;
        if (start_det) begin
            state_d = S_DEVADDR;
            cnt_d   = '0;
        end else if (stop_det) begin
            state_d = S_IDLE;
            cnt_d   = '0;
            ptr_d   = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_IGNORE: begin
                end
                S_DEVADDR: begin
                    if (scl_rise && cnt_q < BITS) begin
                        sh_d  = {sh_q[6:0], sda_lvl};
                        cnt_d = cnt_q + 4'd1;
                    end else if (scl_fall && cnt_q == BITS) begin
                        cnt_d = '0;
                        if (sh_q[7:1] == DEV_ADDR && (!sh_q[0] || ptr_q))
                            state_d = S_DEVACK;
                        else
                            state_d = S_IGNORE;
                    end
                end
                S_DEVACK: begin
                    if (scl_fall) begin
                        if (sh_q[0]) begin
                            state_d = S_RDDATA;
                            sh_d    = rd_byte;
                        end else begin
                            state_d = S_REGADDR;
                        end
                    end
                end
                S_REGADDR: begin
                    if (scl_rise && cnt_q < BITS) begin
                        sh_d  = {sh_q[6:0], sda_lvl};
                        cnt_d = cnt_q + 4'd1;
                    end else if (scl_fall && cnt_q == BITS) begin
                        cnt_d = '0;
                        if (sh_q == REG_ADDR) begin
                            state_d = S_REGACK;
                            ptr_d   = 1'b1;
                        end else begin
                            state_d = S_IGNORE;
                        end
                    end
                end
                S_REGACK: begin
                    if (scl_fall) state_d = S_WRDATA;
                end
                S_WRDATA: begin
                    if (scl_rise && cnt_q < BITS) begin
                        sh_d  = {sh_q[6:0], sda_lvl};
                        cnt_d = cnt_q + 4'd1;
                    end else if (scl_fall && cnt_q == BITS) begin
                        cnt_d   = '0;
                        wr_en   = 1'b1;
                        state_d = S_WRACK;
                    end
                end
                S_WRACK: begin
                    if (scl_fall) state_d = S_IGNORE;
                end
                S_RDDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == BITS - 4'd1) begin
                            state_d = S_RDACK;
                            cnt_d   = '0;
                        end else begin
                            sh_d  = {sh_q[6:0], 1'b1};
                            cnt_d = cnt_q + 4'd1;
                        end
                    end
                end
                S_RDACK: begin
                    if (scl_rise) state_d = S_IGNORE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_DEVACK, S_REGACK, S_WRACK: sda_pull = 1'b1;
            S_RDDATA:                    sda_pull = ~sh_q[7];
            default:                     sda_pull = 1'b0;
        endcase
    end

    assign wr_data = sh_q;
    assign state   = state_q;
endmodule

// File: rtl/fault_cause_reg.sv
module fault_cause_reg
    import fcr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter logic [7:0] REG_ADDR    = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_manual,
    input  logic              fail_wdog,
    input  logic              fail_low1,
    input  logic              fail_low2,
    input  logic              fail_low3,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [FLAG_W-1:0] flags
);
    logic              sda_lvl;
    logic              start_det;
    logic              stop_det;
    logic              scl_rise;
    logic              scl_fall;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic [FLAG_W-1:0] fail_vec;
    fcr_state_e        state_w;

    always_comb begin
        fail_vec           = '0;
        fail_vec[BIT_MAN]  = fail_manual;
        fail_vec[BIT_WDG]  = fail_wdog;
        fail_vec[BIT_LOW1] = fail_low1;
        fail_vec[BIT_LOW2] = fail_low2;
        fail_vec[BIT_LOW3] = fail_low3;
    end

    fcr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    fcr_slave_fsm #(.DEV_ADDR(DEV_ADDR), .REG_ADDR(REG_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .rd_byte   (flags),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .state     (state_w)
    );

    fcr_flag_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_vec (fail_vec),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .flags    (flags)
    );
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker
    import fcr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] flags,
    input logic [7:0] fail_mask,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input fcr_state_e state,
    input logic       sda_pull,
    input logic       start_det,
    input logic       stop_det
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> flags == 8'h00);

    assert_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((flags & ~$past(flags)) == 8'h00));

    assert_event_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_mask != 8'h00) |=> ((flags & $past(fail_mask)) == 8'h00));

    assert_fail_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fail_mask != 8'h00) |=> ((flags & $past(fail_mask)) == 8'h00));

    assert_write_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags == ($past(wr_data) & ~$past(fail_mask)));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> state == S_IDLE);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start_det) |=> (state == S_IDLE && !sda_pull));
endmodule

bind fault_cause_reg fcr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .fail_mask (fail_vec),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .state     (state_w),
    .sda_pull  (sda_pull),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/fault_cause_reg_bench.sv
module fault_cause_reg_bench;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_m = 1'b0, ev_w = 1'b0, ev1 = 1'b0, ev2 = 1'b0, ev3 = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull;
    logic [7:0] flags;
    logic sda_bus;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    bit cmp_en = 0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    fault_cause_reg u_fault_cause_reg (
        .clk (clk), .rst_n (rst_n),
        .fail_manual (ev_m), .fail_wdog (ev_w),
        .fail_low1 (ev1), .fail_low2 (ev2), .fail_low3 (ev3),
        .scl_in (scl_m), .sda_in (sda_bus),
        .sda_pull (sda_pull), .flags (flags)
    );

    function automatic logic [7:0] evmask();
        return {ev_m, ev_w, 3'b000, ev3, ev2, ev1};
    endfunction

    // R2 reference: sticky active-low flags, updated every clock
    always @(posedge clk) begin
        if (!rst_n) model <= 8'h00;
        else if (cmp_en) model <= model & ~evmask();
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            n_checks++;
            if (flags !== model) begin
                n_errors++;
                $display("FAIL R2 cycle model: flags=%h expected=%h", flags, model);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q / 2);
        ack = ~sda_bus;
        wq(Q - Q / 2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] d, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q / 2);
            d[i] = sda_bus;
            wq(Q - Q / 2);
            scl_m = 1'b0; wq(Q);
        end
        // master NACK: SDA stays released, slave must not pull
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q / 2);
        rel = sda_bus;
        wq(Q - Q / 2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic reg_write(logic [7:0] ra, logic [7:0] d,
                             output logic a1, output logic a2, output logic a3);
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(ra, a2);
        send_byte(d, a3);
        bus_stop();
    endtask

    task automatic reg_read(output logic [7:0] d, output logic [3:0] acks);
        logic a1, a2, a3, rel;
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'hFF, a2);
        bus_start();
        send_byte({DEV, 1'b1}, a3);
        recv_byte(d, rel);
        bus_stop();
        acks = {a1, a2, a3, rel};
    endtask

    task automatic arm(logic [7:0] d, logic [7:0] held);
        logic a1, a2, a3;
        cmp_en = 0;
        reg_write(8'hFF, d, a1, a2, a3);
        chk("R4 write acks", {29'd0, a1, a2, a3}, 32'd7);
        model = d & ~held;
        wq(2);
        cmp_en = 1;
    endtask

    task automatic pulse(int which);
        case (which)
            0: ev_m = 1'b1;
            1: ev_w = 1'b1;
            2: ev1 = 1'b1;
            3: ev2 = 1'b1;
            default: ev3 = 1'b1;
        endcase
        @(negedge clk);
        ev_m = 1'b0; ev_w = 1'b0; ev1 = 1'b0; ev2 = 1'b0; ev3 = 1'b0;
        wq(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic a1, a2, a3;
        logic [7:0] rd;
        logic [3:0] acks;

        wq(5);
        chk("R1 reset flags", flags, 8'h00);
        chk("R1 reset pull", sda_pull, 1'b0);
        rst_n = 1'b1;
        wq(3);
        cmp_en = 1;
        chk("R1 after release", flags, 8'h00);

        // R2 events before arming leave zeros
        pulse(0);
        chk("R2 unarmed stays zero", flags, 8'h00);

        arm(8'hFF, 8'h00);
        chk("R4 armed value", flags, 8'hFF);

        // R3 bit map
        pulse(0); chk("R3 manual bit7", flags, 8'h7F);
        reg_read(rd, acks);
        chk("R6 read value", rd, 8'h7F);
        chk("R6 read acks and release", acks, 4'b1111);
        pulse(3); chk("R3 low2 bit1", flags, 8'h7D);
        pulse(1); chk("R3 watchdog bit6", flags, 8'h3D);
        pulse(2); chk("R3 low1 bit0", flags, 8'h3C);
        pulse(4); chk("R3 low3 bit2", flags, 8'h38);
        wq(50);
        chk("R2 sticky hold", flags, 8'h38);
        reg_read(rd, acks);
        chk("R6 read after faults", rd, 8'h38);
        chk("R10 released after stop", sda_pull, 1'b0);

        arm(8'hFF, 8'h00);
        chk("R2 re-arm", flags, 8'hFF);

        // R7 wrong register address
        reg_write(8'h10, 8'h00, a1, a2, a3);
        chk("R7 dev ack", a1, 1'b1);
        chk("R7 reg nack", a2, 1'b0);
        chk("R7 data nack", a3, 1'b0);
        chk("R7 no write", flags, 8'hFF);

        // R8 wrong device address
        bus_start();
        send_byte({7'h23, 1'b0}, a1);
        send_byte(8'hFF, a2);
        bus_stop();
        chk("R8 dev nack", a1, 1'b0);
        chk("R8 stays released", a2, 1'b0);

        // R9 frame without start
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'hFF, a2);
        send_byte(8'h00, a3);
        bus_stop();
        chk("R9 no ack without start", {29'd0, a1, a2, a3}, 32'd0);
        chk("R9 no write without start", flags, 8'hFF);

        // R11 read without pointer in this transaction
        bus_start();
        send_byte({DEV, 1'b1}, a1);
        bus_stop();
        chk("R11 read nack without pointer", a1, 1'b0);
        arm(8'hFF, 8'h00);
        bus_start();
        send_byte({DEV, 1'b1}, a1);
        bus_stop();
        chk("R11 pointer cleared by stop", a1, 1'b0);

        // R5 event held across the write commit
        ev_w = 1'b1;
        arm(8'hFF, 8'h40);
        ev_w = 1'b0;
        wq(20);
        chk("R5 failure wins over write", flags, 8'hBF);

        // R3 reserved bits untouched by events
        arm(8'hFF, 8'h00);
        pulse(0); pulse(1); pulse(2); pulse(3); pulse(4);
        chk("R3 reserved bits kept", flags, 8'h38);
        arm(8'h00, 8'h00);
        chk("R4 write zero", flags, 8'h00);
        reg_read(rd, acks);
        chk("R10 repeated start read", rd, 8'h00);
        chk("R10 acks", acks, 4'b1111);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule